// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Generator

This block is the timing engine of a clocked master on a single-wire, open-drain bus. On a start strobe it runs one bus operation: a bus reset followed by a presence check, a zero-bit write, a one-bit write, or a one-bit read. It pulls the shared line low through an open-drain output and watches the line through a synchronizer. Software or a higher sequencer chains these operations into bytes, searches and CRC checks; none of that lives here.

All durations are counted in ticks of a one-microsecond strobe supplied from outside, so the system clock frequency does not matter. A speed input picks the standard or the fast (overdrive) timing set. Operation and speed are latched at the start strobe. Each operation finishes only after its minimum slot length and its recovery time have passed, so a new start may be given as soon as `done` is seen. The chosen tick counts are: reset low 480 / 60, presence sample 550 / 69 (70 / 9 after release), reset total 960 / 108 (480 / 48 after release); write-zero low 65 / 8; write-one and read low 6 / 1; read sample 13 / 3; and non-reset slot total 70 / 10. In each pair the first value is standard speed and the second is overdrive.

Top module: `owm_slot_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done` and `line_pull_low` are 0, and `presence` and `rx_bit` are 0.
- R2: A `start` is taken only when `busy` is 0. It latches `op` (0 = bus reset, 1 = write zero, 2 = write one, 3 = read) and `overdrive` (1 = fast timing). A `start` while `busy` is 1 has no effect on the running operation or on its timing.
- R3: `line_pull_low` rises on the clock after an accepted start. It stays high for exactly 480/60 ticks for a reset, 65/8 ticks for a write zero, and 6/1 ticks for a write one or a read (standard/overdrive).
- R4: `busy` stays high for exactly 960/108 ticks for a reset and 70/10 ticks for any other operation, counted from the accepted start.
- R5: For a reset, the line is sampled when the tick count reaches 550 (standard) or 69 (overdrive). `presence` becomes 1 if the line is low at that point and 0 otherwise. A slave pulse that ends before the sample point gives 0.
- R6: For a read, the line is sampled at tick 13 (standard) or 3 (overdrive). `rx_bit` takes the line level at that point.
- R7: `done` is a one-clock pulse in the first clock after `busy` falls, and once per operation.
- R8: A write leaves both `presence` and `rx_bit` unchanged. A reset leaves `rx_bit` unchanged, and a read leaves `presence` unchanged.
- R9: Time advances only on clocks where `us_tick` is 1. With no ticks, the operation holds its state and `busy` stays high.
- R10: `line_pull_low` is high only while `busy` is high, and only as one unbroken interval at the start of each operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| start | input | 1 | Request one operation |
| op | input | 2 | Operation code: 0 reset, 1 write zero, 2 write one, 3 read |
| overdrive | input | 1 | 1 selects fast timing |
| line_in | input | 1 | Level seen on the bus line |
| line_pull_low | output | 1 | 1 turns on the open-drain pull-down |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse at the end of an operation |
| presence | output | 1 | Result of the last reset: a slave answered |
| rx_bit | output | 1 | Result of the last read |

## Verification
Each of the four operations runs at both speeds. Pull-down length and total length are measured in ticks, which separates the two timing sets and the per-operation lengths. Resets run against a slave that answers across the sample point, a slave that is silent, and a slave whose pulse ends before the sample point, so a sampler that triggers at the wrong time is caught. Reads run against a slave that holds the line low and one that leaves it high. Directed cases cover a start issued mid-slot with a different operation and speed, a pause in the tick stream, and the retention of each result across the other operations.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        OWM_RST = 2'd0,
        OWM_WR0 = 2'd1,
        OWM_WR1 = 2'd2,
        OWM_RD  = 2'd3
    } owm_op_e;

endpackage

// File: rtl/owm_timing.sv
// Selects the tick counts for the latched operation and speed.
module owm_timing
    import owm_pkg::*;
#(
    parameter int CW          = 10,
    parameter int STD_RST_LOW = 480,
    parameter int STD_RST_SMP = 70,
    parameter int STD_RST_REC = 480,
    parameter int STD_W0_LOW  = 65,
    parameter int STD_W1_LOW  = 6,
    parameter int STD_RD_SMP  = 13,
    parameter int STD_SLOT    = 70,
    parameter int OD_RST_LOW  = 60,
    parameter int OD_RST_SMP  = 9,
    parameter int OD_RST_REC  = 48,
    parameter int OD_W0_LOW   = 8,
    parameter int OD_W1_LOW   = 1,
    parameter int OD_RD_SMP   = 3,
    parameter int OD_SLOT     = 10
) (
    input  owm_op_e         op,
    input  logic            od,
    output logic [CW-1:0]   low_len,
    output logic [CW-1:0]   smp_at,
    output logic [CW-1:0]   tot_len,
    output logic            smp_en
);

    localparam int NSET = 2;

    logic [CW-1:0] rst_low [NSET];
    logic [CW-1:0] rst_smp [NSET];
    logic [CW-1:0] rst_tot [NSET];
    logic [CW-1:0] w0_low  [NSET];
    logic [CW-1:0] w1_low  [NSET];
    logic [CW-1:0] rd_smp  [NSET];
    logic [CW-1:0] slot    [NSET];

    // index 0: standard speed, index 1: overdrive
    for (genvar s = 0; s < NSET; s++) begin : g_set
        if (s == 0) begin : g_std
            assign rst_low[s] = CW'(STD_RST_LOW);
            assign rst_smp[s] = CW'(STD_RST_LOW + STD_RST_SMP);
            assign rst_tot[s] = CW'(STD_RST_LOW + STD_RST_REC);
            assign w0_low[s]  = CW'(STD_W0_LOW);
            assign w1_low[s]  = CW'(STD_W1_LOW);
            assign rd_smp[s]  = CW'(STD_RD_SMP);
            assign slot[s]    = CW'(STD_SLOT);
        end else begin : g_od
            assign rst_low[s] = CW'(OD_RST_LOW);
            assign rst_smp[s] = CW'(OD_RST_LOW + OD_RST_SMP);
            assign rst_tot[s] = CW'(OD_RST_LOW + OD_RST_REC);
            assign w0_low[s]  = CW'(OD_W0_LOW);
            assign w1_low[s]  = CW'(OD_W1_LOW);
            assign rd_smp[s]  = CW'(OD_RD_SMP);
            assign slot[s]    = CW'(OD_SLOT);
        end
    end

    logic sel;
    assign sel = od;

    always_comb begin
        smp_en  = 1'b0;
        smp_at  = '0;
        low_len = w1_low[sel];
        tot_len = slot[sel];
        unique case (op)
            OWM_RST: begin
                low_len = rst_low[sel];
                smp_at  = rst_smp[sel];
                tot_len = rst_tot[sel];
                smp_en  = 1'b1;
            end
            OWM_WR0: low_len = w0_low[sel];
            OWM_WR1: low_len = w1_low[sel];
            OWM_RD: begin
                smp_at = rd_smp[sel];
                smp_en = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/owm_line_sync.sv
// Brings the asynchronous bus level into the clock domain; idles high.
module owm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign sh_d[i] = d;
        end else begin : g_next
            assign sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
    import owm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STD_RST_LOW = 480,
    parameter int STD_RST_SMP = 70,
    parameter int STD_RST_REC = 480,
    parameter int STD_W0_LOW  = 65,
    parameter int STD_W1_LOW  = 6,
    parameter int STD_RD_SMP  = 13,
    parameter int STD_SLOT    = 70,
    parameter int OD_RST_LOW  = 60,
    parameter int OD_RST_SMP  = 9,
    parameter int OD_RST_REC  = 48,
    parameter int OD_W0_LOW   = 8,
    parameter int OD_W1_LOW   = 1,
    parameter int OD_RD_SMP   = 3,
    parameter int OD_SLOT     = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       overdrive,
    input  logic       line_in,
    output logic       line_pull_low,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       rx_bit
);

    localparam int STD_MAX = (STD_RST_LOW + STD_RST_REC > STD_SLOT) ?
                             (STD_RST_LOW + STD_RST_REC) : STD_SLOT;
    localparam int OD_MAX  = (OD_RST_LOW + OD_RST_REC > OD_SLOT) ?
                             (OD_RST_LOW + OD_RST_REC) : OD_SLOT;
    localparam int MAX_T   = (STD_MAX > OD_MAX) ? STD_MAX : OD_MAX;
    localparam int CW      = $clog2(MAX_T + 1);

    typedef struct packed {
        logic          busy;
        logic          low;
        logic          done;
        logic          pres;
        logic          rbit;
        logic          od;
        owm_op_e       op;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t r_q, r_d;

    logic          line_s;
    logic [CW-1:0] low_len, smp_at, tot_len;
    logic          smp_en;

    owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    owm_timing #(
        .CW(CW),
        .STD_RST_LOW(STD_RST_LOW), .STD_RST_SMP(STD_RST_SMP),
        .STD_RST_REC(STD_RST_REC), .STD_W0_LOW(STD_W0_LOW),
        .STD_W1_LOW(STD_W1_LOW),   .STD_RD_SMP(STD_RD_SMP),
        .STD_SLOT(STD_SLOT),
        .OD_RST_LOW(OD_RST_LOW),   .OD_RST_SMP(OD_RST_SMP),
        .OD_RST_REC(OD_RST_REC),   .OD_W0_LOW(OD_W0_LOW),
        .OD_W1_LOW(OD_W1_LOW),     .OD_RD_SMP(OD_RD_SMP),
        .OD_SLOT(OD_SLOT)
    ) u_timing (
        .op      (r_q.op),
        .od      (r_q.od),
        .low_len (low_len),
        .smp_at  (smp_at),
        .tot_len (tot_len),
        .smp_en  (smp_en)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy = 1'b1;
                r_d.low  = 1'b1;
                r_d.op   = owm_op_e'(op);
                r_d.od   = overdrive;
                r_d.cnt  = '0;
            end
        end else if (us_tick) begin
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_d.cnt >= low_len) r_d.low = 1'b0;
            if (smp_en && (r_d.cnt == smp_at)) begin
                if (r_q.op == OWM_RST) r_d.pres = ~line_s;
                else                   r_d.rbit = line_s;
            end
            if (r_d.cnt == tot_len) begin
                r_d.busy = 1'b0;
                r_d.low  = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{busy: 1'b0, low: 1'b0, done: 1'b0, pres: 1'b0,
                     rbit: 1'b0, od: 1'b0, op: OWM_RST, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign line_pull_low = r_q.low;
    assign busy          = r_q.busy;
    assign done          = r_q.done;
    assign presence      = r_q.pres;
    assign rx_bit        = r_q.rbit;

    // R10
    pull_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull_low |-> busy);

    // R10
    single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_pull_low) |=> !line_pull_low);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R2
    busy_hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.op) && $stable(r_q.od)));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !us_tick) |=> ($stable(r_q.cnt) && busy));

    // R8
    write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (r_q.op == OWM_WR0 || r_q.op == OWM_WR1))
        |=> ($stable(presence) && $stable(rx_bit)));

endmodule

// File: tb/owm_slot_engine_bench.sv
module owm_slot_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic       od_i = 1'b0;
    logic       line;
    logic       line_pull_low, busy, done, presence, rx_bit;

    always #5 clk = ~clk;

    owm_slot_engine u_owm_slot_engine (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
        .op(op_i), .overdrive(od_i), .line_in(line),
        .line_pull_low(line_pull_low), .busy(busy), .done(done),
        .presence(presence), .rx_bit(rx_bit)
    );

    int n_run = 0;
    int n_fail = 0;

    // tick generator: one pulse every 4 clocks when enabled
    logic       tick_en = 1'b1;
    logic [1:0] div = 2'd0;
    always @(posedge clk) begin
        div     <= div + 2'd1;
        us_tick <= tick_en && (div == 2'd3);
    end

    // monitor
    int low_ticks, busy_ticks, done_cnt, low_rises, idle_low_err;
    logic prev_low = 1'b0;
    initial begin
        low_ticks = 0; busy_ticks = 0; done_cnt = 0; low_rises = 0;
        idle_low_err = 0;
    end
    always @(negedge clk) begin
        if (start && !busy) begin
            low_ticks = 0; busy_ticks = 0; done_cnt = 0; low_rises = 0;
        end
        if (busy && us_tick) busy_ticks++;
        if (line_pull_low && us_tick) low_ticks++;
        if (done) done_cnt++;
        if (line_pull_low && !prev_low) low_rises++;
        if (line_pull_low && !busy) idle_low_err++;
        prev_low = line_pull_low;
    end

    // slave model: 0 silent, 1 presence, 2 read zero, 3 short presence
    logic [1:0] sm = 2'd0;
    logic       cur_od = 1'b0;
    logic       slave_low;
    always_comb begin
        slave_low = 1'b0;
        if (busy) begin
            case (sm)
                2'd1: slave_low = cur_od ? (busy_ticks >= 63 && busy_ticks <= 90)
                                         : (busy_ticks >= 495 && busy_ticks <= 630);
                2'd2: slave_low = cur_od ? (busy_ticks <= 5) : (busy_ticks <= 30);
                2'd3: slave_low = cur_od ? (busy_ticks >= 61 && busy_ticks <= 66)
                                         : (busy_ticks >= 490 && busy_ticks <= 530);
                default: slave_low = 1'b0;
            endcase
        end
    end
    assign line = ~(line_pull_low | slave_low);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic launch(input logic [1:0] o, input logic d, input logic [1:0] s);
        @(posedge clk); #1;
        sm = s; cur_od = d;
        op_i = o; od_i = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    typedef struct packed {
        logic [1:0] op;
        logic       od;
        logic [1:0] sm;
        logic [9:0] lo;
        logic [9:0] tot;
        logic [1:0] kind;  // 0 none, 1 presence, 2 read bit
        logic       ex;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 2'd1, 10'd480, 10'd960, 2'd1, 1'b1},
        '{2'd0, 1'b0, 2'd0, 10'd480, 10'd960, 2'd1, 1'b0},
        '{2'd0, 1'b0, 2'd3, 10'd480, 10'd960, 2'd1, 1'b0},
        '{2'd0, 1'b1, 2'd1, 10'd60,  10'd108, 2'd1, 1'b1},
        '{2'd0, 1'b1, 2'd0, 10'd60,  10'd108, 2'd1, 1'b0},
        '{2'd0, 1'b1, 2'd3, 10'd60,  10'd108, 2'd1, 1'b0},
        '{2'd1, 1'b0, 2'd0, 10'd65,  10'd70,  2'd0, 1'b0},
        '{2'd1, 1'b1, 2'd0, 10'd8,   10'd10,  2'd0, 1'b0},
        '{2'd2, 1'b0, 2'd0, 10'd6,   10'd70,  2'd0, 1'b0},
        '{2'd2, 1'b1, 2'd0, 10'd1,   10'd10,  2'd0, 1'b0},
        '{2'd3, 1'b0, 2'd2, 10'd6,   10'd70,  2'd2, 1'b0},
        '{2'd3, 1'b0, 2'd0, 10'd6,   10'd70,  2'd2, 1'b1},
        '{2'd3, 1'b1, 2'd2, 10'd1,   10'd10,  2'd2, 1'b0},
        '{2'd3, 1'b1, 2'd0, 10'd1,   10'd10,  2'd2, 1'b1}
    };

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 busy in reset", busy, 0);
        chk("R1 pull in reset", line_pull_low, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 pull", line_pull_low, 0);
        chk("R1 presence", presence, 0);
        chk("R1 rx_bit", rx_bit, 0);

        // table of operations
        for (int v = 0; v < NV; v++) begin
            launch(VT[v].op, VT[v].od, VT[v].sm);
            wait_done();
            chk("R3 low ticks", low_ticks, int'(VT[v].lo));
            chk("R4 busy ticks", busy_ticks, int'(VT[v].tot));
            chk("R7 done pulses", done_cnt, 1);
            chk("R10 low intervals", low_rises, 1);
            if (VT[v].kind == 2'd1) chk("R5 presence", presence, int'(VT[v].ex));
            if (VT[v].kind == 2'd2) chk("R6 rx_bit", rx_bit, int'(VT[v].ex));
        end

        // R2: start while busy is ignored (different op and speed)
        launch(2'd1, 1'b0, 2'd0);
        repeat (20) @(posedge clk);
        #1; op_i = 2'd0; od_i = 1'b1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        wait_done();
        chk("R2 low ticks kept", low_ticks, 65);
        chk("R2 busy ticks kept", busy_ticks, 70);
        chk("R2 single done", done_cnt, 1);

        // R8: results kept across other operations
        launch(2'd0, 1'b0, 2'd1);
        wait_done();
        chk("R8 presence set", presence, 1);
        launch(2'd3, 1'b1, 2'd0);
        wait_done();
        chk("R8 read sets rx_bit", rx_bit, 1);
        chk("R8 read keeps presence", presence, 1);
        launch(2'd1, 1'b0, 2'd0);
        wait_done();
        launch(2'd2, 1'b1, 2'd0);
        wait_done();
        chk("R8 write keeps presence", presence, 1);
        chk("R8 write keeps rx_bit", rx_bit, 1);
        launch(2'd0, 1'b1, 2'd0);
        wait_done();
        chk("R8 reset clears presence", presence, 0);
        chk("R8 reset keeps rx_bit", rx_bit, 1);

        // R9: ticks paused mid-slot
        launch(2'd2, 1'b0, 2'd0);
        repeat (10) @(posedge clk);
        #1; tick_en = 1'b0;
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk("R9 busy held without ticks", busy, 1);
        @(posedge clk); #1; tick_en = 1'b1;
        wait_done();
        chk("R9 busy ticks with pause", busy_ticks, 70);
        chk("R9 low ticks with pause", low_ticks, 6);

        // R10: never pulled while idle
        chk("R10 idle pull", idle_low_err, 0);

        finish_run();
    end

endmodule